// File: doc/BRIEF.md
# SPI Bus Master with Word FIFOs

This block is an SPI master driven over a small 32-bit register bus. Software loads words into a transmit queue. The engine sends each word on `mosi`, one bit per serial clock period, and captures `miso` at the same time into a receive queue. The serial clock is divided down from the system clock by a 16-bit half-period count. A control word sets the word length (1 to 16 bits), the idle level of the clock, the edge on which data is sampled, whether the most significant bit goes first, and an internal loopback path.

Software drives chip select itself through other means. It normally queues up to eight words and enables the "transmitter drained" interrupt. When that interrupt fires it reads the received words back and queues the next burst. Each queue can be reduced to a single-word buffer. A soft-reset bit in the control word holds the engine and both queues empty for as long as it is set.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset every register reads zero, `sck` and `mosi` are low and `irq` is low.
- R2: Register word addresses (byte offset >> 2) are: 0 divisor, 1 transmit data (write), 2 receive data (read), 3 control, 4 interrupt enable, 6 mode. The divisor reads back its low 16 bits, control its low 13 bits, interrupt enable only bit 2, and mode only bit 0. Mode has no effect on serial behaviour.
- R3: Each half period of `sck` lasts exactly D system cycles, where D is the divisor value. A divisor of 0 gives a half period of 65536 cycles.
- R4: Control bit 6 (polarity) sets the idle level of `sck`. With control bit 5 (phase) clear, `mosi` is valid before the first clock edge and is sampled on the first edge. With phase set, data is sampled on the second edge. A receiver that samples `mosi` on the matching edges sees the transmitted word in all four combinations.
- R5: Control bits [3:0] hold the word length minus one. Control bit 4 set sends the most significant bit first, and clear sends the least significant bit first. Transmit bits above the length are ignored, and received words are right-aligned with zeros above.
- R6: With loopback off, the bit present on `miso` at each sampling edge is assembled into the received word.
- R7: With control bit 10 (loopback) set, the received word equals the transmitted word and `miso` is ignored.
- R8: Shifting begins once master (bit 8) and enable (bit 9) are both set and the transmit queue holds a word. Queued words follow one another with no idle gap, so N words take N x 2 x length x D cycles.
- R9: With interrupt-enable bit 2 set, `irq` is high exactly while the transmit queue is empty and no word is being shifted.
- R10: With control bit 11 set, the transmit queue holds 8 words. Writes to a full queue are dropped.
- R11: With control bit 12 set, the receive queue holds 8 words. A word that completes while the queue is full is discarded and sets a sticky overflow flag. A receive-data read returns the oldest word in bits [15:0] (zero if the queue is empty), returns the overflow flag in bit 16, pops the word and clears the flag.
- R12: With control bit 11 or bit 12 clear, the corresponding queue holds only one word.
- R13: While control bit 7 (soft reset) is set, both queues are emptied, writes to the transmit queue are lost, the overflow flag is cleared and no shifting takes place.
- R14: While master or enable is clear, `sck` stays at the polarity level, `mosi` stays low, and queued words wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits [4:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Transmitter-drained interrupt |

## Verification
On every cycle, the assertions check the following. The serial clock moves only at half-period boundaries. Both queue counts stay within depth. A dropped received word always raises the overflow flag. Soft reset always leaves the queues and engine empty, and a halted engine never stays busy. `irq` never coincides with an active clock or data level. Bit order, the four clock modes, the exact half-period length including the 65536 case, and back-to-back timing can only be shown by the bench. The same holds for external `miso` capture, queue depth limits, single-word queues, and the data returned by reads. The bench does this by decoding `mosi` and measuring cycle counts at the pins.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  localparam int WORD_W   = 16;
  localparam int DIV_W    = 16;
  localparam int CTL_BITS = 13;

  localparam int B_MSBF = 4;
  localparam int B_CPHA = 5;
  localparam int B_CPOL = 6;
  localparam int B_SRST = 7;
  localparam int B_MSTR = 8;
  localparam int B_EN   = 9;
  localparam int B_LOOP = 10;
  localparam int B_TXFE = 11;
  localparam int B_RXFE = 12;

  localparam logic [2:0] A_DIV  = 3'd0;
  localparam logic [2:0] A_TX   = 3'd1;
  localparam logic [2:0] A_RX   = 3'd2;
  localparam logic [2:0] A_CTL  = 3'd3;
  localparam logic [2:0] A_IEN  = 3'd4;
  localparam logic [2:0] A_MODE = 3'd6;

  // half-period length in system cycles; zero stands for the full range
  function automatic logic [DIV_W:0] half_len(input logic [DIV_W-1:0] d);
    return (d == '0) ? {1'b1, {DIV_W{1'b0}}} : {1'b0, d};
  endfunction

  // word bit carried by serial bit k
  function automatic logic [3:0] bit_pos(input logic [3:0] k, input logic [3:0] wm1,
                                         input logic msbf);
    return msbf ? (wm1 - k) : k;
  endfunction
endpackage

// File: rtl/sfm_fifo.sv
module sfm_fifo #(
  parameter int W = 16,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          single,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (count == '0);
  assign full    = single ? !empty : (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= adv(wp);
      if (do_pop)  rp <= adv(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end
endmodule

// File: rtl/sfm_shift.sv
module sfm_shift
  import sfm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              msbf,
  input  logic              loop,
  input  logic [3:0]        wm1,
  input  logic [DIV_W-1:0]  div,
  input  logic              tx_avail,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              miso,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_word,
  output logic              sck,
  output logic              mosi,
  output logic              busy,
  output logic              tick
);
  logic [DIV_W:0]    cnt, hl;
  logic [4:0]        ph;
  logic [WORD_W-1:0] txs, rxs;
  logic [3:0]        pos;
  logic              last, rx_in, start;

  assign hl      = half_len(div);
  assign tick    = busy && (cnt == hl - 1'b1);
  assign last    = (ph == {wm1, 1'b1});
  assign pos     = bit_pos(ph[4:1], wm1, msbf);
  assign mosi    = busy & txs[pos];
  assign sck     = cpol ^ (busy & (ph[0] ^ cpha));
  assign rx_in   = loop ? mosi : miso;
  assign start   = run && !busy && tx_avail;
  assign rx_push = run && tick && last;
  assign tx_pop  = start || (rx_push && tx_avail);
  assign rx_word = rxs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; ph <= '0; txs <= '0; rxs <= '0;
    end else if (!run) begin
      busy <= 1'b0; cnt <= '0; ph <= '0;
    end else if (!busy) begin
      if (tx_avail) begin
        busy <= 1'b1; cnt <= '0; ph <= '0; txs <= tx_word; rxs <= '0;
      end
    end else if (tick) begin
      cnt <= '0;
      if (!ph[0]) rxs[pos] <= rx_in;
      if (last) begin
        ph <= '0;
        if (tx_avail) begin
          txs <= tx_word; rxs <= '0;
        end else begin
          busy <= 1'b0;
        end
      end else begin
        ph <= ph + 5'd1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import sfm_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic        irq
);
  logic [DIV_W-1:0]    div_q;
  logic [CTL_BITS-1:0] ctl_q;
  logic                ien_q, mode_q, ovf_q;
  logic [2:0]          a;
  logic                wr, rd, srst, run, cpol;
  logic                tx_pop, tx_empty, tx_full, rx_push, rx_full, rx_empty, rx_rd, rx_drop;
  logic                busy, tick;
  logic [WORD_W-1:0]   tx_dout, rx_dout, rx_word;
  logic [CW-1:0]       tx_count, rx_count;
  logic                unused_bits;

  assign a     = bus_addr[4:2];
  assign wr    = bus_en && bus_we;
  assign rd    = bus_en && !bus_we;
  assign rx_rd = rd && (a == A_RX);
  assign srst  = ctl_q[B_SRST];
  assign cpol  = ctl_q[B_CPOL];
  assign run   = ctl_q[B_EN] && ctl_q[B_MSTR] && !srst;
  assign rx_drop = rx_push && rx_full;
  assign irq   = ien_q && !busy && tx_empty;
  assign unused_bits = &{1'b0, bus_wdata[31:16], bus_addr[1:0], tx_full};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0; ctl_q <= '0; ien_q <= 1'b0; mode_q <= 1'b0;
    end else if (wr) begin
      case (a)
        A_DIV:   div_q  <= bus_wdata[DIV_W-1:0];
        A_CTL:   ctl_q  <= bus_wdata[CTL_BITS-1:0];
        A_IEN:   ien_q  <= bus_wdata[2];
        A_MODE:  mode_q <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_q <= 1'b0;
    else if (srst)    ovf_q <= 1'b0;
    else if (rx_drop) ovf_q <= 1'b1;
    else if (rx_rd)   ovf_q <= 1'b0;
  end

  always_comb begin
    case (a)
      A_DIV:   bus_rdata = {16'h0, div_q};
      A_RX:    bus_rdata = {15'h0, ovf_q, (rx_empty ? 16'h0 : rx_dout)};
      A_CTL:   bus_rdata = {{(32-CTL_BITS){1'b0}}, ctl_q};
      A_IEN:   bus_rdata = {29'h0, ien_q, 2'b00};
      A_MODE:  bus_rdata = {31'h0, mode_q};
      default: bus_rdata = 32'h0;
    endcase
  end

  sfm_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(srst), .single(!ctl_q[B_TXFE]),
    .push(wr && (a == A_TX)), .pop(tx_pop), .din(bus_wdata[WORD_W-1:0]),
    .dout(tx_dout), .count(tx_count), .full(tx_full), .empty(tx_empty));

  sfm_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(srst), .single(!ctl_q[B_RXFE]),
    .push(rx_push), .pop(rx_rd), .din(rx_word),
    .dout(rx_dout), .count(rx_count), .full(rx_full), .empty(rx_empty));

  sfm_shift u_eng (
    .clk(clk), .rst_n(rst_n), .run(run), .cpol(cpol), .cpha(ctl_q[B_CPHA]),
    .msbf(ctl_q[B_MSBF]), .loop(ctl_q[B_LOOP]), .wm1(ctl_q[3:0]), .div(div_q),
    .tx_avail(!tx_empty), .tx_word(tx_dout), .miso(miso),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
    .sck(sck), .mosi(mosi), .busy(busy), .tick(tick));
endmodule

// File: rtl/sfm_checker.sv
module sfm_checker #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sck,
  input logic          mosi,
  input logic          irq,
  input logic          run,
  input logic          srst,
  input logic          cpol,
  input logic          cpha,
  input logic          busy,
  input logic          tick,
  input logic          rx_drop,
  input logic          ovf,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count
);
  assert_sck_on_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick) && $stable(cpol) && $stable(cpha)) |-> $stable(sck));

  assert_irq_idle_lines_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sck == cpol && !mosi));

  assert_txq_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CW'(DEPTH));

  assert_rxq_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));

  assert_drop_sets_ovf_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> ovf);

  assert_srst_flush_R13: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (tx_count == '0 && rx_count == '0 && !busy));

  assert_halt_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !busy);
endmodule

bind spi_fifo_master sfm_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .irq(irq), .run(run),
  .srst(srst), .cpol(cpol), .cpha(ctl_q[5]), .busy(busy), .tick(tick),
  .rx_drop(rx_drop), .ovf(ovf_q), .tx_count(tx_count), .rx_count(rx_count));

// File: tb/sim_spi_fifo_master.sv
module sim_spi_fifo_master;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sck, mosi, miso, irq;

  int n_chk = 0, n_bad = 0;

  // serial receiver model on mosi
  logic        mon_on = 1'b0, mcpol = 1'b0, mcpha = 1'b0;
  logic [31:0] mon = '0;
  int          mon_n = 0;
  // serial sender model on miso (mode 0, msb first)
  logic        slave_on = 1'b0, miso_hold = 1'b1;
  logic [7:0]  spat = '0;
  int          sidx = 0;

  assign miso = slave_on ? ((sidx < 8) ? spat[7 - sidx] : 1'b0) : miso_hold;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fifo_master u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .irq(irq));

  always @(sck) begin
    if (mon_on && (sck === (mcpha ? mcpol : ~mcpol))) begin
      mon = {mon[30:0], mosi};
      mon_n++;
    end
  end

  always @(negedge sck) if (slave_on) sidx++;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] ad, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = ad; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] ad, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = ad;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] mkctl(input int wm1, input bit msbf, input bit cpha,
      input bit cpol, input bit loop, input bit mstr, input bit en,
      input bit txfe, input bit rxfe, input bit srst);
    return 32'(wm1 & 15) | (32'(msbf) << 4) | (32'(cpha) << 5) | (32'(cpol) << 6)
         | (32'(srst) << 7) | (32'(mstr) << 8) | (32'(en) << 9) | (32'(loop) << 10)
         | (32'(txfe) << 11) | (32'(rxfe) << 12);
  endfunction

  localparam logic [4:0] R_DIV = 5'h00, R_TX = 5'h04, R_RX = 5'h08, R_CTL = 5'h0C,
                         R_IEN = 5'h10, R_MODE = 5'h18;

  task automatic t_reset;
    logic [31:0] d;
    check("R1 sck", {31'h0, sck}, 0);
    check("R1 mosi", {31'h0, mosi}, 0);
    check("R1 irq", {31'h0, irq}, 0);
    rd(R_DIV, d);  check("R1 div", d, 0);
    rd(R_CTL, d);  check("R1 ctl", d, 0);
    rd(R_IEN, d);  check("R1 ien", d, 0);
    rd(R_MODE, d); check("R1 mode", d, 0);
    rd(R_RX, d);   check("R1 rx", d, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(R_DIV, 32'hFFFF_1234); rd(R_DIV, d); check("R2 div", d, 32'h1234);
    wr(R_CTL, 32'hFFFF_FFFF); rd(R_CTL, d); check("R2 ctl", d, 32'h1FFF);
    wr(R_CTL, 0);
    wr(R_IEN, 32'hFFFF_FFFF); rd(R_IEN, d); check("R2 ien", d, 32'h4);
    wr(R_IEN, 0);
    wr(R_MODE, 32'hFFFF_FFFF); rd(R_MODE, d); check("R2 mode", d, 32'h1);
    wr(R_MODE, 0); rd(R_MODE, d); check("R2 mode clear", d, 0);
    wr(R_DIV, 7);
  endtask

  task automatic send_mon(input logic [31:0] ctl_run, input bit cpol, input bit cpha,
                          input logic [15:0] w, input int wait_cyc);
    wr(R_CTL, ctl_run & ~32'h300);
    mcpol = cpol; mcpha = cpha; mon = 0; mon_n = 0; mon_on = 1'b1;
    wr(R_CTL, ctl_run);
    wr(R_TX, {16'h0, w});
    idle(wait_cyc);
    mon_on = 1'b0;
  endtask

  // R4 and R7: four clock modes in loopback with miso held high
  task automatic t_modes;
    logic [31:0] d;
    miso_hold = 1'b1;
    for (int m = 0; m < 4; m++) begin
      bit pl = m[1], pa = m[0];
      send_mon(mkctl(7, 1, pa, pl, 1, 1, 1, 1, 1, 0), pl, pa, 16'h00C6, 150);
      check("R4 mosi word", mon, 32'hC6);
      check("R4 edge count", mon_n, 8);
      check("R4 idle level", {31'h0, sck}, {31'h0, pl});
      rd(R_RX, d); check("R7 loopback rx", d, 32'hC6);
    end
  endtask

  // R5: bit order and word length
  task automatic t_order;
    logic [31:0] d;
    send_mon(mkctl(7, 0, 0, 0, 1, 1, 1, 1, 1, 0), 0, 0, 16'h001E, 150);
    check("R5 lsb first", mon, 32'h78);
    rd(R_RX, d); check("R5 lsb rx", d, 32'h1E);
    send_mon(mkctl(15, 1, 0, 0, 1, 1, 1, 1, 1, 0), 0, 0, 16'hBEEF, 260);
    check("R5 16-bit", mon, 32'hBEEF);
    check("R5 16 edges", mon_n, 16);
    rd(R_RX, d); check("R5 16-bit rx", d, 32'hBEEF);
    send_mon(mkctl(11, 1, 0, 0, 1, 1, 1, 1, 1, 0), 0, 0, 16'hFABC, 200);
    check("R5 12-bit", mon, 32'hABC);
    rd(R_RX, d); check("R5 right aligned", d, 32'h0ABC);
  endtask

  // R6: capture from external miso, mode 0
  task automatic t_miso;
    logic [31:0] d;
    wr(R_CTL, mkctl(7, 1, 0, 0, 0, 1, 0, 1, 1, 0));
    spat = 8'h5A; sidx = 0; slave_on = 1'b1;
    wr(R_CTL, mkctl(7, 1, 0, 0, 0, 1, 1, 1, 1, 0));
    wr(R_TX, 0);
    idle(150);
    slave_on = 1'b0;
    rd(R_RX, d); check("R6 miso capture", d, 32'h5A);
  endtask

  // R8, R9, R10: burst timing, interrupt and queue depth
  task automatic t_burst;
    logic [31:0] d;
    int cyc = 0, t_s = -1, t_i = -1;
    bit ps, pi;
    wr(R_IEN, 0);
    wr(R_CTL, mkctl(7, 1, 1, 0, 1, 1, 0, 1, 1, 0));
    for (int i = 0; i < 10; i++) wr(R_TX, 32'h10 + i);
    check("R14 held sck", {31'h0, sck}, 0);
    wr(R_CTL, mkctl(7, 1, 1, 0, 1, 1, 1, 1, 1, 0));
    ps = sck; pi = 0;
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = R_IEN; bus_wdata = 4;
    @(negedge clk); bus_en = 1'b0; bus_we = 1'b0;
    if (sck && !ps) t_s = cyc;
    for (int c = 0; c < 1200; c++) begin
      ps = sck; pi = irq;
      @(negedge clk); cyc++;
      if (t_s < 0 && sck && !ps) t_s = cyc;
      if (t_i < 0 && irq && !pi) t_i = cyc;
    end
    if (t_s < 0) t_s = 0;
    check("R8 back-to-back duration", t_i - t_s, 8 * 16 * 7);
    check("R9 irq after drain", {31'h0, irq}, 1);
    for (int i = 0; i < 8; i++) begin
      rd(R_RX, d); check("R10 queued word", d, 32'h10 + i);
    end
    rd(R_RX, d); check("R10 excess writes dropped", d, 0);
    wr(R_TX, 32'h55); idle(2);
    check("R9 irq low while busy", {31'h0, irq}, 0);
    idle(150); rd(R_RX, d);
    wr(R_IEN, 0);
  endtask

  // R11: receive overflow and empty read
  task automatic t_ovf;
    logic [31:0] d;
    for (int i = 0; i < 10; i++) wr(R_TX, 32'h20 + i);
    idle(10 * 112 + 100);
    rd(R_RX, d); check("R11 overflow flag", d, 32'h10020);
    for (int i = 1; i < 8; i++) begin
      rd(R_RX, d); check("R11 oldest kept, flag cleared", d, 32'h20 + i);
    end
    rd(R_RX, d); check("R11 empty read", d, 0);
  endtask

  // R12: single-word queues
  task automatic t_single;
    logic [31:0] d;
    wr(R_CTL, mkctl(7, 1, 0, 0, 1, 1, 0, 0, 1, 0));
    wr(R_TX, 32'h31); wr(R_TX, 32'h32); wr(R_TX, 32'h33);
    wr(R_CTL, mkctl(7, 1, 0, 0, 1, 1, 1, 0, 1, 0));
    idle(400);
    rd(R_RX, d); check("R12 tx single word", d, 32'h31);
    rd(R_RX, d); check("R12 tx others dropped", d, 0);
    wr(R_CTL, mkctl(7, 1, 0, 0, 1, 1, 1, 1, 0, 0));
    wr(R_TX, 32'h41); wr(R_TX, 32'h42);
    idle(300);
    rd(R_RX, d); check("R12 rx single word", d, 32'h10041);
    rd(R_RX, d); check("R12 rx holds one", d, 0);
  endtask

  // R13: soft reset flushes both queues
  task automatic t_srst;
    logic [31:0] d;
    wr(R_CTL, mkctl(7, 1, 0, 0, 1, 1, 1, 1, 1, 0));
    wr(R_TX, 32'h61); idle(150);
    wr(R_CTL, mkctl(7, 1, 0, 0, 1, 1, 0, 1, 1, 0));
    wr(R_TX, 32'h62); wr(R_TX, 32'h63);
    wr(R_CTL, mkctl(7, 1, 0, 0, 1, 1, 1, 1, 1, 1));
    wr(R_TX, 32'h64);
    wr(R_IEN, 4);
    check("R13 tx queue empty", {31'h0, irq}, 1);
    rd(R_RX, d); check("R13 rx flushed", d, 0);
    mcpol = 0; mcpha = 0; mon_n = 0; mon_on = 1'b1;
    wr(R_CTL, mkctl(7, 1, 0, 0, 1, 1, 1, 1, 1, 0));
    idle(200);
    mon_on = 1'b0;
    check("R13 nothing shifted", mon_n, 0);
    rd(R_RX, d); check("R13 rx still empty", d, 0);
    wr(R_IEN, 0);
  endtask

  // R14: master or enable clear holds the lines
  task automatic t_halt;
    logic [31:0] d;
    mcpol = 1; mcpha = 0; mon_n = 0; mon_on = 1'b1;
    wr(R_CTL, mkctl(7, 1, 0, 1, 1, 1, 0, 1, 1, 0));
    wr(R_TX, 32'h77); idle(200);
    check("R14 enable clear sck", {31'h0, sck}, 1);
    check("R14 enable clear mosi", {31'h0, mosi}, 0);
    wr(R_CTL, mkctl(7, 1, 0, 1, 1, 0, 1, 1, 1, 0)); idle(200);
    check("R14 master clear sck", {31'h0, sck}, 1);
    check("R14 no edges", mon_n, 0);
    rd(R_RX, d); check("R14 rx empty", d, 0);
    wr(R_CTL, mkctl(7, 1, 0, 1, 1, 1, 1, 1, 1, 0)); idle(200);
    mon_on = 1'b0;
    rd(R_RX, d); check("R14 word waited", d, 32'h77);
  endtask

  task automatic half_period(input logic [31:0] dv, input int exp, input int lim);
    int n = 0;
    wr(R_CTL, mkctl(7, 1, 1, 0, 1, 1, 0, 1, 1, 0));
    wr(R_DIV, dv);
    wr(R_TX, 32'hAA);
    wr(R_CTL, mkctl(7, 1, 1, 0, 1, 1, 1, 1, 1, 0));
    for (int c = 0; c < 20 && !sck; c++) @(negedge clk);
    while (sck && n < lim) begin
      n++; @(negedge clk);
    end
    check("R3 half period", n, exp);
    wr(R_CTL, mkctl(7, 1, 1, 0, 1, 1, 1, 1, 1, 1));
    wr(R_CTL, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_regs;
    t_modes;
    t_order;
    t_miso;
    t_burst;
    t_ovf;
    t_single;
    t_srst;
    t_halt;
    half_period(9, 9, 100);
    half_period(0, 65536, 70000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule